// File: doc/BRIEF.md
# Modulo Timer with Buffered Reload

This block is a 16-bit up-counting timer reached through a small 32-bit register bus. A control register selects whether the counter runs from the system clock or stands still, picks a power-of-two prescale ratio, and enables the overflow interrupt. The counter climbs by one on every prescaled tick. When it reaches the modulo limit, the next tick drops it back to a programmable start value instead of zero and raises an overflow flag.

The start and limit registers are double-buffered. Bus writes land in a holding copy, and the copy takes effect only while the counter clock is switched off. Software therefore stops the clock, writes the new period, and restarts. Any bus write to the count register reloads the counter from the active start value. A timer driver uses the block either as a free-running time base or as a periodic or one-shot event source. For the event source, the limit is programmed to the wanted tick count minus one.

Top module: `modtmr`

## Requirements
- R1: After reset the control register reads 0, the count reads 0, the limit reads 0x0000FFFF, the start value reads 0, and `irq` is low.
- R2: While running, the count rises by exactly one per prescaled tick as long as it is not equal to the active limit.
- R3: On a tick with the count equal to the limit, the counter takes the active start value and the overflow flag is set. With start 0 and limit N-1, exactly one overflow occurs every N ticks. The flag never rises without such a wrap.
- R4: A bus write of any data to the count register (offset 0x04) loads the active start value into the counter. The written data is discarded, and the load has priority over a tick in the same cycle.
- R5: Writes to the limit (0x08) and start value (0x4C) registers go to a holding copy. The active value, which is what reads return, takes the holding copy only on cycles where the clock-select field is 0. Bits 31:16 of the written data are ignored.
- R6: Control bits 4:3 are the clock-select field. Value 1 runs the counter from the system clock. Value 0 stops it. Values 2 and 3 also hold the count but do not commit buffered values.
- R7: Control bits 2:0 are the prescale field p. A run started from a stopped state gives its first tick 2^p clock cycles after the start write and one tick every 2^p cycles after that. The divider restarts whenever the clock-select field is 0.
- R8: Control bit 5 enables the interrupt. `irq` is high exactly when that bit and the overflow flag are both 1.
- R9: Control bit 6 is the overflow flag. A control write with bit 6 = 0 clears it only if a control read has returned the flag as 1 since the previous control write. Writing 1 leaves it unchanged. An overflow in the same cycle as a clear leaves the flag set.
- R10: The control register is at offset 0x00, and any other offset reads 0. Count, limit and start reads return the 16-bit value zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Overflow interrupt request |

## Verification
The properties assume `bus_wr` and `bus_rd` are never both asserted for the control offset in one cycle, and that the bus is idle during reset. The stimulus drives one bus operation at a time, one cycle each, so that assumption always holds. After every write to the start or limit register, the bench inserts an idle cycle before it depends on the committed value. It changes the prescale field only in the same write that starts the counter from a stopped state, so the tick count over a run is exactly the cycle count shifted right by the prescale value.

// File: rtl/modtmr_pkg.sv
package modtmr_pkg;
   // clock-select encodings
   localparam int         CS_W   = 2;
   localparam logic [1:0] CS_OFF = 2'd0;
   localparam logic [1:0] CS_SYS = 2'd1;
endpackage

// File: rtl/modtmr_prediv.sv
// Power-of-two tick divider; restarts whenever run is low.
module modtmr_prediv #(
   parameter int PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic [PS_W-1:0] ps,
   output logic            tick
);
   localparam int DIV_W = (1 << PS_W) - 1;

   if (PS_W < 1 || PS_W > 5) begin : g_bad_ps
      $error("modtmr_prediv: PS_W out of range");
   end

   logic [DIV_W-1:0] pcnt_q;
   logic [DIV_W-1:0] mask;

   assign mask = ~({DIV_W{1'b1}} << ps);
   assign tick = run && ((pcnt_q & mask) == mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pcnt_q <= '0;
      else if (!run)  pcnt_q <= '0;
      else            pcnt_q <= pcnt_q + 1'b1;
   end
endmodule

// File: rtl/modtmr_shadow.sv
// Register with optional holding copy committed on demand.
module modtmr_shadow #(
   parameter int          W        = 16,
   parameter logic [W-1:0] RST_VAL = '0,
   parameter bit          BUFFERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         commit,
   output logic [W-1:0] q
);
   if (BUFFERED) begin : g_buf
      logic [W-1:0] hold_q;
      logic [W-1:0] act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= RST_VAL;
            act_q  <= RST_VAL;
         end else begin
            if (wr)     hold_q <= wdata;
            if (commit) act_q  <= hold_q;
         end
      end
      assign q = act_q;
   end else begin : g_direct
      logic [W-1:0] act_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  act_q <= RST_VAL;
         else if (wr) act_q <= wdata;
      end
      assign q = act_q;
   end
endmodule

// File: rtl/modtmr_core.sv
// Up-counter with start-value reload at the limit.
module modtmr_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         load,
   input  logic [W-1:0] start_val,
   input  logic [W-1:0] limit_val,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   logic [W-1:0] cnt_q;

   assign wrap = tick && !load && (cnt_q == limit_val);
   assign cnt  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (load)  cnt_q <= start_val;
      else if (wrap)  cnt_q <= start_val;
      else if (tick)  cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/modtmr.sv
module modtmr
   import modtmr_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 8,
   parameter int                CNT_W    = 16,
   parameter int                PS_W     = 3,
   parameter bit                BUFFERED = 1'b1,
   parameter logic [ADDR_W-1:0] OFS_CTRL = 8'h00,
   parameter logic [ADDR_W-1:0] OFS_CNT  = 8'h04,
   parameter logic [ADDR_W-1:0] OFS_LIM  = 8'h08,
   parameter logic [ADDR_W-1:0] OFS_STRT = 8'h4C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq
);
   localparam int CS_LSB   = PS_W;
   localparam int IE_BIT   = PS_W + CS_W;
   localparam int FLAG_BIT = IE_BIT + 1;

   if (FLAG_BIT >= DATA_W) begin : g_bad_ctrl
      $error("modtmr: control fields do not fit the data width");
   end
   if (CNT_W < 2 || CNT_W >= DATA_W) begin : g_bad_cnt
      $error("modtmr: CNT_W must be between 2 and DATA_W-1");
   end

   // bus decode
   logic ctrl_wr, ctrl_rd, cnt_load, lim_wr, strt_wr;
   assign ctrl_wr  = bus_wr && (bus_addr == OFS_CTRL);
   assign ctrl_rd  = bus_rd && (bus_addr == OFS_CTRL);
   assign cnt_load = bus_wr && (bus_addr == OFS_CNT);
   assign lim_wr   = bus_wr && (bus_addr == OFS_LIM);
   assign strt_wr  = bus_wr && (bus_addr == OFS_STRT);

   // control register
   logic [PS_W-1:0] ps_q;
   logic [CS_W-1:0] cs_q;
   logic            ie_q;
   logic            flag_q;
   logic            armed_q;
   logic            clr_req;
   logic            cnt_wrap;
   logic            tick;
   logic            run;
   logic            commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ps_q <= '0;
         cs_q <= CS_OFF;
         ie_q <= 1'b0;
      end else if (ctrl_wr) begin
         ps_q <= bus_wdata[0 +: PS_W];
         cs_q <= bus_wdata[CS_LSB +: CS_W];
         ie_q <= bus_wdata[IE_BIT];
      end
   end

   // clear is armed by reading the flag as 1, consumed by the next control write
   assign clr_req = ctrl_wr && armed_q && !bus_wdata[FLAG_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         flag_q  <= 1'b0;
      end else begin
         if (ctrl_wr)                armed_q <= 1'b0;
         else if (ctrl_rd && flag_q) armed_q <= 1'b1;
         if (cnt_wrap)               flag_q  <= 1'b1;
         else if (clr_req)           flag_q  <= 1'b0;
      end
   end

   assign run    = (cs_q == CS_SYS);
   assign commit = (cs_q == CS_OFF);

   // datapath
   logic [CNT_W-1:0] lim_act, strt_act, cnt_q;

   modtmr_prediv #(.PS_W(PS_W)) u_prediv (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .ps    (ps_q),
      .tick  (tick)
   );

   modtmr_shadow #(.W(CNT_W), .RST_VAL({CNT_W{1'b1}}), .BUFFERED(BUFFERED)) u_lim (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (lim_wr),
      .wdata  (bus_wdata[CNT_W-1:0]),
      .commit (commit),
      .q      (lim_act)
   );

   modtmr_shadow #(.W(CNT_W), .RST_VAL('0), .BUFFERED(BUFFERED)) u_strt (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (strt_wr),
      .wdata  (bus_wdata[CNT_W-1:0]),
      .commit (commit),
      .q      (strt_act)
   );

   modtmr_core #(.W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .load      (cnt_load),
      .start_val (strt_act),
      .limit_val (lim_act),
      .cnt       (cnt_q),
      .wrap      (cnt_wrap)
   );

   logic unused_wbits;
   assign unused_wbits = ^bus_wdata[DATA_W-1:CNT_W];

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         OFS_CTRL: begin
            bus_rdata[0 +: PS_W]      = ps_q;
            bus_rdata[CS_LSB +: CS_W] = cs_q;
            bus_rdata[IE_BIT]         = ie_q;
            bus_rdata[FLAG_BIT]       = flag_q;
         end
         OFS_CNT:  bus_rdata[CNT_W-1:0] = cnt_q;
         OFS_LIM:  bus_rdata[CNT_W-1:0] = lim_act;
         OFS_STRT: bus_rdata[CNT_W-1:0] = strt_act;
         default:  bus_rdata = '0;
      endcase
   end

   assign irq = flag_q & ie_q;
endmodule

// File: rtl/modtmr_chk.sv
module modtmr_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         tick,
   input logic         load,
   input logic         wrap,
   input logic         clr_req,
   input logic         flag,
   input logic         ie,
   input logic         irq,
   input logic [1:0]   cs,
   input logic [W-1:0] cnt,
   input logic [W-1:0] start_act,
   input logic [W-1:0] limit_act
);
   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt != limit_act) |=> (cnt == $past(cnt) + 1'b1)); // R2

   AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (cnt == $past(start_act) && flag)); // R3

   AST_FLAG_NEEDS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(wrap)); // R3

   AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(start_act))); // R4

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cs != 2'd0) |=> ($stable(limit_act) && $stable(start_act))); // R5

   AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cs != 2'd1 && !load) |=> $stable(cnt)); // R6

   AST_IRQ_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && ie) |=> irq); // R8

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && clr_req) |=> flag); // R9
endmodule

bind modtmr modtmr_chk #(.W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .load      (cnt_load),
   .wrap      (cnt_wrap),
   .clr_req   (clr_req),
   .flag      (flag_q),
   .ie        (ie_q),
   .irq       (irq),
   .cs        (cs_q),
   .cnt       (cnt_q),
   .start_act (strt_act),
   .limit_act (lim_act)
);

// File: tb/modtmr_bench.sv
module modtmr_bench;
   localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h04, A_LIM = 8'h08, A_STRT = 8'h4C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;
   bit          done = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   modtmr u_modtmr (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   typedef struct { logic [31:0] exp; string tag; } item_t;
   item_t sbq[$];
   int checks = 0, fails = 0;

   // reference model state
   logic [15:0] m_cnt = 0, m_strt = 0, m_lim = 16'hFFFF;
   logic [2:0]  m_ps = 0;
   logic        m_ie = 0, m_flag = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pop one expected item per read cycle
   always @(negedge clk) begin
      if (bus_rd) begin
         item_t it;
         if (sbq.size() == 0) chk("scoreboard-empty", 32'd1, 32'd0);
         else begin
            it = sbq.pop_front();
            chk(it.tag, bus_rdata, it.exp);
         end
      end
   end

   task automatic idle(int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
      sbq.push_back('{exp, tag});
      bus_rd = 1'b1; bus_addr = a;
      @(posedge clk); #1;
      bus_rd = 1'b0;
   endtask

   function automatic logic [31:0] ctrlv(logic [1:0] cs, logic fl);
      return 32'(m_ps) | (32'(cs) << 3) | (32'(m_ie) << 5) | (32'(fl) << 6);
   endfunction

   task automatic model_ticks(int t);
      for (int k = 0; k < t; k++) begin
         if (m_cnt == m_lim) begin m_cnt = m_strt; m_flag = 1'b1; end
         else m_cnt = m_cnt + 16'd1;
      end
   endtask

   // start, wait n cycles, stop: ticks = (n+1) >> ps
   task automatic run(int n);
      wr(A_CTRL, ctrlv(2'd1, 1'b1));
      idle(n);
      wr(A_CTRL, ctrlv(2'd0, 1'b1));
      model_ticks((n + 1) >> m_ps);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(A_CTRL, 32'h0, "R1 ctrl");
      rd(A_CNT, 32'h0, "R1 count");
      rd(A_LIM, 32'h0000FFFF, "R1 limit");
      rd(A_STRT, 32'h0, "R1 start");
      chk("R1 irq", 32'(irq), 32'd0);
      // R10 unmapped offset
      rd(8'h10, 32'h0, "R10 unmapped");

      // R4 count write loads start, data ignored
      wr(A_STRT, 32'h5); m_strt = 5; idle(1);
      rd(A_STRT, 32'h5, "R5 start commit");
      wr(A_CNT, 32'hDEADBEEF); m_cnt = m_strt;
      rd(A_CNT, 32'h5, "R4 count load");
      // R5 upper bits ignored
      wr(A_LIM, 32'hFFFF0009); m_lim = 9; idle(1);
      rd(A_LIM, 32'h9, "R5 limit low bits");

      // R2 counting
      run(2);
      rd(A_CNT, 32'(m_cnt), "R2 count after 3 ticks");
      rd(A_CTRL, ctrlv(2'd0, m_flag), "R2 no overflow");
      // R3 wrap to start
      run(3);
      rd(A_CNT, 32'(m_cnt), "R3 wrap to start");
      rd(A_CTRL, ctrlv(2'd0, m_flag), "R3 flag set");
      chk("R8 irq masked", 32'(irq), 32'd0);

      // R9 clear after read, then R3 period of N=4
      wr(A_STRT, 32'h0); m_strt = 0;
      wr(A_LIM, 32'h3); m_lim = 3; idle(1);
      wr(A_CNT, 32'h0); m_cnt = 0;
      rd(A_CTRL, ctrlv(2'd0, 1'b1), "R9 flag before clear");
      wr(A_CTRL, ctrlv(2'd0, 1'b0)); m_flag = 0;
      rd(A_CTRL, ctrlv(2'd0, 1'b0), "R9 flag cleared");
      run(2);
      rd(A_CTRL, ctrlv(2'd0, m_flag), "R3 no overflow in 3 ticks");
      run(0);
      rd(A_CNT, 32'(m_cnt), "R3 period 4 count");
      rd(A_CTRL, ctrlv(2'd0, m_flag), "R3 overflow on 4th tick");

      // R8 / R9 write-0 without read, write-1
      m_ie = 1;
      wr(A_CTRL, ctrlv(2'd0, 1'b1));
      wr(A_CTRL, ctrlv(2'd0, 1'b0));
      chk("R8 irq high", 32'(irq), 32'd1);
      rd(A_CTRL, ctrlv(2'd0, 1'b1), "R9 unarmed write 0 kept flag");
      wr(A_CTRL, ctrlv(2'd0, 1'b1));
      rd(A_CTRL, ctrlv(2'd0, 1'b1), "R9 write 1 kept flag");
      wr(A_CTRL, ctrlv(2'd0, 1'b0)); m_flag = 0;
      chk("R8 irq low after clear", 32'(irq), 32'd0);
      rd(A_CTRL, ctrlv(2'd0, 1'b0), "R9 armed clear");

      // R6 / R5 reserved select holds count, no commit
      wr(A_LIM, 32'hFFFF); m_lim = 16'hFFFF; idle(1);
      wr(A_CNT, 32'h0); m_cnt = 0;
      wr(A_CTRL, ctrlv(2'd2, 1'b1));
      wr(A_LIM, 32'h33);
      wr(A_STRT, 32'h11);
      idle(3);
      rd(A_LIM, 32'hFFFF, "R5 limit held while select=2");
      rd(A_STRT, 32'h0, "R5 start held while select=2");
      rd(A_CNT, 32'h0, "R6 select=2 holds count");
      wr(A_CTRL, ctrlv(2'd0, 1'b1)); idle(1);
      m_lim = 16'h33; m_strt = 16'h11;
      rd(A_LIM, 32'h33, "R5 limit committed");
      rd(A_STRT, 32'h11, "R5 start committed");

      // R5 write while running
      wr(A_LIM, 32'hFFFF); wr(A_STRT, 32'h0); idle(1);
      m_lim = 16'hFFFF; m_strt = 0;
      wr(A_CNT, 32'h0); m_cnt = 0;
      wr(A_CTRL, ctrlv(2'd1, 1'b1));
      wr(A_LIM, 32'h100);
      rd(A_LIM, 32'hFFFF, "R5 limit held while running");
      wr(A_CTRL, ctrlv(2'd0, 1'b1)); model_ticks(3);
      idle(1); m_lim = 16'h100;
      rd(A_LIM, 32'h100, "R5 limit committed after stop");
      rd(A_CNT, 32'(m_cnt), "R6 select=1 counted 3");

      // R7 prescaler
      wr(A_CNT, 32'h0); m_cnt = 0;
      m_ps = 2; run(9);
      rd(A_CNT, 32'(m_cnt), "R7 divide by 4");
      m_ps = 3; run(20);
      rd(A_CNT, 32'(m_cnt), "R7 divide by 8");
      m_ps = 7; run(300);
      rd(A_CNT, 32'(m_cnt), "R7 divide by 128");
      rd(A_CTRL, ctrlv(2'd0, m_flag), "R10 ctrl fields");

      // R9 overflow and clear in the same cycle
      m_ps = 0;
      wr(A_STRT, 32'h2); wr(A_LIM, 32'h3); idle(1);
      m_strt = 2; m_lim = 3;
      wr(A_CNT, 32'h0); m_cnt = 2;
      run(1);
      rd(A_CTRL, ctrlv(2'd0, m_flag), "R3 flag before set-wins");
      wr(A_CTRL, ctrlv(2'd1, 1'b1));
      rd(A_CTRL, ctrlv(2'd1, 1'b1), "R9 arm while running");
      wr(A_CTRL, ctrlv(2'd1, 1'b0));
      wr(A_CTRL, ctrlv(2'd0, 1'b1));
      model_ticks(3);
      rd(A_CTRL, ctrlv(2'd0, 1'b1), "R9 set wins over clear");
      rd(A_CNT, 32'(m_cnt), "R3 count after set-wins");
      chk("R8 irq after set-wins", 32'(irq), 32'd1);

      idle(2);
      chk("scoreboard drained", 32'(sbq.size()), 32'd0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule